// File: doc/BRIEF.md
# Three-Phase Reactive Energy Accumulator

This block integrates reactive power on three phases into three signed energy registers. Voltage and phase-shifted current samples come in already filtered. A 2-bit mode selects how each phase's current term is built: a phase's own current, its difference with phase B's current, or zero. The product of the phase voltage and this current term goes into a 40-bit signed per-phase sum once per sample period. A sample period is a fixed number of clock cycles, four by default.

Each time a phase's internal sum crosses a multiple of 2^FRAC_W, one energy unit is produced, with the sign of the sample. A per-phase signed counter divides these units by a programmable 8-bit ratio before they step the visible register by one. The visible register wraps in two's complement.

Software reads a register through a small read port. An optional clear-on-read setting zeroes the register that was read. A sticky interrupt flag reports every change of the register's second-highest bit, which marks the half-full point in either direction.

Top module: `rvar_energy_acc`

## Requirements
- R1: With mode 2'b00, phase A integrates Va×Ia, phase B integrates Vb×Ib and phase C integrates Vc×Ic.
- R2: With mode 2'b01, phase A integrates Va×(Ia−Ib), phase B integrates nothing and phase C integrates Vc×(Ic−Ib).
- R3: With mode 2'b10, phase A integrates Va×(Ia−Ib), phase B integrates nothing and phase C integrates Vc×Ic.
- R4: With mode 2'b11, no phase integrates anything and all energy registers hold their value.
- R5: One sample is integrated on every TICK_DIV-th rising edge after reset is released, starting with edge TICK_DIV. No energy register changes on any other edge, except through a clear.
- R6: A phase's 40-bit sum produces one unit, with the sign of the product, each time floor(sum / 2^FRAC_W) changes. The register steps by ±1 once per div_val units of the same direction. A div_val of 0 acts as 1.
- R7: A register at the largest positive value (0x7FFF by default) that receives a positive step becomes the most negative value (0x8000).
- R8: A register at the most negative value that receives a negative step becomes the largest positive value.
- R9: When irq_en is 1, irq is set on the edge where bit ENERGY_W−2 (bit 14 by default) of any energy register changes. When irq_en is 0, irq is not set.
- R10: irq stays at 1 until an edge where irq_clr is 1 and no new set event happens.
- R11: rd_data shows, without delay, the register chosen by rd_sel (0 = A, 1 = B, 2 = C, 3 = zero). If rd_en and rd_clr_en are both 1 at an edge, that register becomes 0 after the edge. A read with rd_clr_en at 0 leaves the register unchanged.
- R12: If a clear and a step fall on the same edge, the register takes the value 0 plus the step.
- R13: Reset sets all energy registers, internal sums and divider counts to zero and sets irq to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Current term selection mode |
| div_val | input | 8 | Unit-to-step division ratio (0 acts as 1) |
| irq_en | input | 1 | Allows half-full events to set irq |
| rd_clr_en | input | 1 | Makes a read clear the selected register |
| va | input | SAMPLE_W | Phase A voltage sample, signed |
| vb | input | SAMPLE_W | Phase B voltage sample, signed |
| vc | input | SAMPLE_W | Phase C voltage sample, signed |
| ia | input | SAMPLE_W | Phase A shifted current sample, signed |
| ib | input | SAMPLE_W | Phase B shifted current sample, signed |
| ic | input | SAMPLE_W | Phase C shifted current sample, signed |
| rd_en | input | 1 | Read strobe for the selected register |
| rd_sel | input | 2 | Register select: 0 A, 1 B, 2 C, 3 none |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| rd_data | output | ENERGY_W | Selected energy register, signed |
| irq | output | 1 | Sticky half-full interrupt flag |

## Verification
Sample edges come at edge 4, 8, 12 and so on after reset is released. A run of N samples is therefore read at the falling edge after edge 4N, and the mode is then forced to 2'b11 so that no later edge can disturb the values being read. rd_data is combinational and is read 1 ns after rd_sel changes, in the same low phase. Clears and irq changes show up at the falling edge just after the edge that causes them, and the tests time their stimulus so that the edge in question is or is not a sample edge, as the test needs. The bench uses an 8-bit register, 8-bit samples and FRAC_W = 16, so that wraparound and the half-full point (bit 6) can be reached within the run time.

// File: rtl/rvar_pkg.sv
package rvar_pkg;

    localparam int NPH   = 3;
    localparam int PH_A  = 0;
    localparam int PH_B  = 1;
    localparam int PH_C  = 2;
    localparam int ACC_W = 40;
    localparam int DIV_W = 8;

    typedef enum logic [1:0] {
        MODE_OWN     = 2'b00,
        MODE_DIFF_AC = 2'b01,
        MODE_DIFF_A  = 2'b10,
        MODE_NONE    = 2'b11
    } term_mode_e;

    // Phase contributes nothing in this mode
    function automatic logic term_zero(term_mode_e m, int ph);
        case (m)
            MODE_OWN:     term_zero = 1'b0;
            MODE_DIFF_AC: term_zero = (ph == PH_B);
            MODE_DIFF_A:  term_zero = (ph == PH_B);
            default:      term_zero = 1'b1;
        endcase
    endfunction

    // Phase uses its own current minus phase B current
    function automatic logic term_diff(term_mode_e m, int ph);
        case (m)
            MODE_DIFF_AC: term_diff = (ph == PH_A) || (ph == PH_C);
            MODE_DIFF_A:  term_diff = (ph == PH_A);
            default:      term_diff = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rvar_tick.sv
module rvar_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/rvar_phase_acc.sv
module rvar_phase_acc import rvar_pkg::*; #(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 24,
    parameter int ENERGY_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic signed [SAMPLE_W-1:0] volt,
    input  logic signed [SAMPLE_W:0]   curr,
    input  logic [DIV_W-1:0]           div_val,
    input  logic                       clr,
    output logic [ENERGY_W-1:0]        energy,
    output logic                       half_flip
);
    localparam int PW   = 2 * SAMPLE_W + 1;
    localparam int HALF = ENERGY_W - 2;
    localparam logic signed [DIV_W:0] ONE = 1;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] acc_q, acc_nx;
    logic                    unit_evt;
    logic signed [DIV_W:0]   dcnt_q, dcnt_nx, dcnt_up, dcnt_dn, div_eff;
    logic                    step_up, step_dn;
    logic [ENERGY_W-1:0]     eng_q, eng_base, eng_nx;

    assign prod     = volt * curr;
    assign acc_nx   = acc_q + {{(ACC_W-PW){prod[PW-1]}}, prod};
    assign unit_evt = tick && (acc_nx[ACC_W-1:FRAC_W] != acc_q[ACC_W-1:FRAC_W]);
    assign dcnt_up  = dcnt_q + ONE;
    assign dcnt_dn  = dcnt_q - ONE;

    always_comb begin
        div_eff = (div_val == '0) ? ONE : {1'b0, div_val};
        dcnt_nx = dcnt_q;
        step_up = 1'b0;
        step_dn = 1'b0;
        if (unit_evt) begin
            if (!prod[PW-1]) begin
                if (dcnt_up >= div_eff) begin
                    dcnt_nx = '0;
                    step_up = 1'b1;
                end else begin
                    dcnt_nx = dcnt_up;
                end
            end else begin
                if (dcnt_dn <= -div_eff) begin
                    dcnt_nx = '0;
                    step_dn = 1'b1;
                end else begin
                    dcnt_nx = dcnt_dn;
                end
            end
        end
    end

    always_comb begin
        eng_base = clr ? '0 : eng_q;
        if (step_up)
            eng_nx = eng_base + ENERGY_W'(1);
        else if (step_dn)
            eng_nx = eng_base - ENERGY_W'(1);
        else
            eng_nx = eng_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            dcnt_q <= '0;
            eng_q  <= '0;
        end else begin
            if (tick)
                acc_q <= acc_nx;
            dcnt_q <= dcnt_nx;
            eng_q  <= eng_nx;
        end
    end

    assign energy    = eng_q;
    assign half_flip = eng_nx[HALF] ^ eng_q[HALF];
endmodule

// File: rtl/rvar_irq.sv
module rvar_irq import rvar_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic [NPH-1:0] flips,
    input  logic           irq_en,
    input  logic           irq_clr,
    output logic           irq
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (irq_en && (|flips))
            flag_q <= 1'b1;
        else if (irq_clr)
            flag_q <= 1'b0;
    end

    assign irq = flag_q;
endmodule

// File: rtl/rvar_energy_acc.sv
module rvar_energy_acc import rvar_pkg::*; #(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 24,
    parameter int ENERGY_W = 16,
    parameter int TICK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode,
    input  logic [DIV_W-1:0]    div_val,
    input  logic                irq_en,
    input  logic                rd_clr_en,
    input  logic [SAMPLE_W-1:0] va,
    input  logic [SAMPLE_W-1:0] vb,
    input  logic [SAMPLE_W-1:0] vc,
    input  logic [SAMPLE_W-1:0] ia,
    input  logic [SAMPLE_W-1:0] ib,
    input  logic [SAMPLE_W-1:0] ic,
    input  logic                rd_en,
    input  logic [1:0]          rd_sel,
    input  logic                irq_clr,
    output logic [ENERGY_W-1:0] rd_data,
    output logic                irq
);
    localparam int CUR_W = SAMPLE_W + 1;

    logic                tick;
    logic [SAMPLE_W-1:0] v_arr [NPH];
    logic [SAMPLE_W-1:0] i_arr [NPH];
    logic [ENERGY_W-1:0] eng   [NPH];
    logic [NPH-1:0]      flips;
    term_mode_e          mode_e;

    assign mode_e = term_mode_e'(mode);
    assign v_arr[PH_A] = va;
    assign v_arr[PH_B] = vb;
    assign v_arr[PH_C] = vc;
    assign i_arr[PH_A] = ia;
    assign i_arr[PH_B] = ib;
    assign i_arr[PH_C] = ic;

    rvar_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar ph = 0; ph < NPH; ph++) begin : g_ph
        logic signed [CUR_W-1:0] own_i, ref_i, cur;
        logic                    clr;

        assign own_i = $signed({i_arr[ph][SAMPLE_W-1], i_arr[ph]});
        assign ref_i = $signed({ib[SAMPLE_W-1], ib});
        assign clr   = rd_en && rd_clr_en && (rd_sel == 2'(ph));

        always_comb begin
            if (term_zero(mode_e, ph))
                cur = '0;
            else if (term_diff(mode_e, ph))
                cur = own_i - ref_i;
            else
                cur = own_i;
        end

        rvar_phase_acc #(
            .SAMPLE_W (SAMPLE_W),
            .FRAC_W   (FRAC_W),
            .ENERGY_W (ENERGY_W)
        ) u_acc (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .volt      ($signed(v_arr[ph])),
            .curr      (cur),
            .div_val   (div_val),
            .clr       (clr),
            .energy    (eng[ph]),
            .half_flip (flips[ph])
        );
    end

    rvar_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .flips   (flips),
        .irq_en  (irq_en),
        .irq_clr (irq_clr),
        .irq     (irq)
    );

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = eng[PH_A];
            2'd1:    rd_data = eng[PH_B];
            2'd2:    rd_data = eng[PH_C];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rvar_energy_acc_chk.sv
module rvar_energy_acc_chk #(
    parameter int EW       = 16,
    parameter int TICK_DIV = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic          irq_en,
    input logic          irq_clr,
    input logic          rd_en,
    input logic          rd_clr_en,
    input logic [1:0]    rd_sel,
    input logic          irq,
    input logic [EW-1:0] eng_a,
    input logic [EW-1:0] eng_b,
    input logic [EW-1:0] eng_c
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          on_tick, clr_a, clr_b, clr_c;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == CW'(TICK_DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign on_tick = (cnt == CW'(TICK_DIV - 1));
    assign clr_a   = rd_en && rd_clr_en && (rd_sel == 2'd0);
    assign clr_b   = rd_en && rd_clr_en && (rd_sel == 2'd1);
    assign clr_c   = rd_en && rd_clr_en && (rd_sel == 2'd2);

    a_r5_quiet_off_tick: assert property (@(posedge clk) disable iff (rst)
        (!on_tick && !clr_a) |=> $stable(eng_a));

    a_r4_reserved_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && !clr_a && !clr_b && !clr_c) |=>
        ($stable(eng_a) && $stable(eng_b) && $stable(eng_c)));

    a_r2_b_idle: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && !clr_b) |=> $stable(eng_b));

    a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
        !clr_c |=> ((eng_c == $past(eng_c)) ||
                    (eng_c == $past(eng_c) + EW'(1)) ||
                    (eng_c == $past(eng_c) - EW'(1))));

    a_r11_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (clr_a && !on_tick) |=> (eng_a == '0));

    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (!irq && !irq_en) |=> !irq);
endmodule

bind rvar_energy_acc rvar_energy_acc_chk #(
    .EW       (ENERGY_W),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .rd_en     (rd_en),
    .rd_clr_en (rd_clr_en),
    .rd_sel    (rd_sel),
    .irq       (irq),
    .eng_a     (eng[0]),
    .eng_b     (eng[1]),
    .eng_c     (eng[2])
);

// File: tb/sim_rvar_energy_acc.sv
module sim_rvar_energy_acc;

    localparam int SW = 8;
    localparam int EW = 8;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  va, vb, vc, ia, ib, ic;
        logic [7:0]  dv;
        logic [15:0] n;
        logic [7:0]  ea, eb, ec;
    } vec_t;

    // mode, va, vb, vc, ia, ib, ic, div, samples, expected A, B, C
    localparam vec_t TBL [5] = '{
        '{2'd0, 8'h80, 8'h40, 8'h64, 8'h80, 8'h40, 8'hCE, 8'd0, 16'd40, 8'h0A, 8'h02, 8'hFC},
        '{2'd1, 8'h32, 8'h7F, 8'hC4, 8'h64, 8'h9C, 8'h14, 8'd3, 16'd50, 8'h02, 8'h00, 8'hFE},
        '{2'd2, 8'h9C, 8'h7F, 8'h1E, 8'h9C, 8'h64, 8'h5A, 8'd1, 16'd30, 8'h09, 8'h00, 8'h01},
        '{2'd3, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h81, 8'h7F, 8'd0, 16'd20, 8'h00, 8'h00, 8'h00},
        '{2'd0, 8'h80, 8'h80, 8'h00, 8'h80, 8'h7F, 8'h55, 8'd2, 16'd60, 8'h07, 8'hF9, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b00;
    logic [7:0]    div_val = '0;
    logic          irq_en = 1'b0, rd_clr_en = 1'b0, rd_en = 1'b0, irq_clr = 1'b0;
    logic [SW-1:0] va = '0, vb = '0, vc = '0, ia = '0, ib = '0, ic = '0;
    logic [1:0]    rd_sel = 2'd0;
    logic [EW-1:0] rd_data;
    logic          irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    rvar_energy_acc #(
        .SAMPLE_W (SW),
        .FRAC_W   (16),
        .ENERGY_W (EW),
        .TICK_DIV (4)
    ) u0 (
        .clk (clk), .rst (rst), .mode (mode), .div_val (div_val),
        .irq_en (irq_en), .rd_clr_en (rd_clr_en),
        .va (va), .vb (vb), .vc (vc), .ia (ia), .ib (ib), .ic (ic),
        .rd_en (rd_en), .rd_sel (rd_sel), .irq_clr (irq_clr),
        .rd_data (rd_data), .irq (irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_samples(input int n);
        repeat (4 * n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0:    return "R1 R5 R6";
            2'd1:    return "R2 R5 R6";
            2'd2:    return "R3 R5 R6";
            default: return "R4 R5";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;

        // Table of mode / divider vectors
        for (int k = 0; k < 5; k++) begin
            mode = TBL[k].mode; div_val = TBL[k].dv;
            va = TBL[k].va; vb = TBL[k].vb; vc = TBL[k].vc;
            ia = TBL[k].ia; ib = TBL[k].ib; ic = TBL[k].ic;
            rd_en = 1'b0; rd_clr_en = 1'b0; irq_en = 1'b0;
            do_reset();
            run_samples(int'(TBL[k].n));
            mode = 2'b11;
            rd(2'd0, v); chk({mode_tag(TBL[k].mode), " phase A"}, v, TBL[k].ea);
            rd(2'd1, v); chk({mode_tag(TBL[k].mode), " phase B"}, v, TBL[k].eb);
            rd(2'd2, v); chk({mode_tag(TBL[k].mode), " phase C"}, v, TBL[k].ec);
            rd(2'd3, v); chk("R11 unused select", v, 8'h00);
        end

        // R7: positive wrap, A product +16384 -> one unit per 4 samples
        mode = 2'b00; div_val = 8'd0;
        va = 8'h80; ia = 8'h80; vb = '0; ib = '0; vc = '0; ic = '0;
        do_reset();
        run_samples(511);
        rd(2'd0, v); chk("R7 at max", v, 8'h7F);
        run_samples(1);
        rd(2'd0, v); chk("R7 wrapped", v, 8'h80);

        // R8: negative wrap, mode 01, A product -16320
        mode = 2'b01; va = 8'h40; ia = 8'h80; ib = 8'h7F;
        do_reset();
        run_samples(514);
        rd(2'd0, v); chk("R8 at min", v, 8'h80);
        run_samples(1);
        rd(2'd0, v); chk("R8 wrapped", v, 8'h7F);

        // R9: half-full event with irq disabled
        mode = 2'b00; va = 8'h80; ia = 8'h80; ib = 8'h00;
        irq_en = 1'b0;
        do_reset();
        run_samples(260);
        chk("R9 disabled irq", {7'd0, irq}, 8'h00);

        // R9 and R10: enabled, bit 6 goes high at 64 units (sample 256)
        irq_en = 1'b1;
        do_reset();
        run_samples(255);
        chk("R9 before half", {7'd0, irq}, 8'h00);
        run_samples(1);
        chk("R9 at half", {7'd0, irq}, 8'h01);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 sticky", {7'd0, irq}, 8'h01);
        irq_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R10 cleared", {7'd0, irq}, 8'h00);

        // R11 / R12: clear-on-read timing, steps at edges 16, 32, 48
        irq_en = 1'b0;
        do_reset();
        repeat (41) @(posedge clk);
        @(negedge clk);
        rd_en = 1'b1; rd_clr_en = 1'b0;
        rd(2'd0, v); chk("R11 read value", v, 8'h02);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        rd(2'd0, v); chk("R11 no clear when disabled", v, 8'h02);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rd_en = 1'b1; rd_clr_en = 1'b1;
        rd(2'd0, v); chk("R11 value before clear", v, 8'h02);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        rd(2'd0, v); chk("R12 clear plus step", v, 8'h01);
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        rd(2'd0, v); chk("R11 cleared", v, 8'h00);

        // R13: reset after activity, irq set beforehand
        irq_en = 1'b1;
        run_samples(300);
        do_reset();
        rd(2'd0, v); chk("R13 A zero", v, 8'h00);
        rd(2'd1, v); chk("R13 B zero", v, 8'h00);
        rd(2'd2, v); chk("R13 C zero", v, 8'h00);
        chk("R13 irq low", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule